// File: doc/BRIEF.md
# Two-Port Word Memory with Byte Lanes

This block is a 4096 by 16-bit storage array reached through two identical, fully independent ports, called left and right. Each port has an address, an active-low enable, an active-low write strobe, an active-low output gate, two active-low byte selects (upper lane is bits 15:8, lower lane is bits 7:0) and an active-low flag-access select. All signals share one clock. Port inputs are sampled at a rising edge, and writes land in the array at that edge.

Read data comes back one cycle later on a data bus with a two-bit valid mask, one bit per lane. Bit 1 covers the upper lane and bit 0 the lower lane. A lane that would be undriven on a physical pin has its valid bit low and its data forced to zero. When the flag-access select asks for the separate flag block, the port raises a combinational hand-off strobe and leaves the array untouched.

When both ports write one address in the same cycle, the left port takes every lane it enables. A one-cycle collision pulse follows.

Top module: `dpram_lanes`

## Requirements
- R1: The array holds 4096 words of 16 bits with a 12-bit address per port. Data written by either port, at any address including 0 and 4095, is returned by a later read on either port.
- R2: With the enable high and the flag select high, the port writes nothing, and its valid mask is 00 in the next cycle.
- R3: With the flag select high and both byte selects high, no lane is read or written, whatever the enable is.
- R4: A write (enable low, write strobe low, flag select high) stores bits 15:8 only when the upper select is low and bits 7:0 only when the lower select is low, whatever the output gate is. The valid mask is 00 in the next cycle.
- R5: A read (enable low, write strobe high, output gate low, flag select high) sets valid bit 1 to the inverse of the upper select and bit 0 to the inverse of the lower select in the next cycle. Each enabled lane carries the stored data.
- R6: With the output gate high, the valid mask is 00 in the next cycle in every mode.
- R7: Both ports reading one address in the same cycle both receive the stored word.
- R8: With the flag select low and either the enable high or both byte selects high, the hand-off strobe is high in that same cycle and the array is not accessed.
- R9: The flag select low together with the enable low and at least one byte select low is illegal. The hand-off strobe stays low, nothing is written, and the valid mask is 00 in the next cycle.
- R10: When both ports write one address in one cycle, each lane the left port enables takes left data, and a lane enabled only by the right port takes right data. The collision output is high in the next cycle, for one cycle per colliding cycle.
- R11: A read in the same cycle as a write to the same address, from the other port, returns the data held before that write.
- R12: After reset the valid masks, read data and collision output are zero, and any lane whose valid bit is low reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_addr | input | 12 | Left word address |
| l_cen_n | input | 1 | Left enable, active low |
| l_rw_n | input | 1 | Left write strobe, low writes |
| l_oe_n | input | 1 | Left output gate, active low |
| l_ub_n | input | 1 | Left upper-lane select, active low |
| l_lb_n | input | 1 | Left lower-lane select, active low |
| l_sem_n | input | 1 | Left flag-access select, active low |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, one cycle after the read |
| l_rvalid | output | 2 | Left lane valid mask, bit 1 upper |
| l_sem_go | output | 1 | Left hand-off strobe to the flag block |
| r_addr | input | 12 | Right word address |
| r_cen_n | input | 1 | Right enable, active low |
| r_rw_n | input | 1 | Right write strobe, low writes |
| r_oe_n | input | 1 | Right output gate, active low |
| r_ub_n | input | 1 | Right upper-lane select, active low |
| r_lb_n | input | 1 | Right lower-lane select, active low |
| r_sem_n | input | 1 | Right flag-access select, active low |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, one cycle after the read |
| r_rvalid | output | 2 | Right lane valid mask, bit 1 upper |
| r_sem_go | output | 1 | Right hand-off strobe to the flag block |
| collide | output | 1 | Pulse after a same-address dual write |

## Verification
The hardest situations to reach are the ones where both ports hit one word in the same cycle: dual writes with overlapping or disjoint lanes, and a read racing a write. With 4096 addresses, random traffic almost never produces them. The random stimulus therefore draws addresses from a 32-entry pool made of the lowest and highest sixteen words, which makes same-address cycles frequent and still covers both ends of the range. Directed cycles first seed every pool word, then force a partial-lane collision, a read beside a write to the same word, and each flag-select combination.

// File: rtl/dpram_lanes.sv
module dpram_lanes #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_cen_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic              l_ub_n,
  input  logic              l_lb_n,
  input  logic              l_sem_n,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic [1:0]        l_rvalid,
  output logic              l_sem_go,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_cen_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic              r_ub_n,
  input  logic              r_lb_n,
  input  logic              r_sem_n,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic [1:0]        r_rvalid,
  output logic              r_sem_go,
  output logic              collide
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = 2;
  localparam int LW    = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];

  logic l_arr, r_arr;
  logic [LANES-1:0] l_we, r_we, l_re, r_re;

  assign l_arr = l_sem_n & ~l_cen_n;
  assign r_arr = r_sem_n & ~r_cen_n;

  assign l_we = (l_arr & ~l_rw_n) ? ~{l_ub_n, l_lb_n} : '0;
  assign r_we = (r_arr & ~r_rw_n) ? ~{r_ub_n, r_lb_n} : '0;
  assign l_re = (l_arr & l_rw_n & ~l_oe_n) ? ~{l_ub_n, l_lb_n} : '0;
  assign r_re = (r_arr & r_rw_n & ~r_oe_n) ? ~{r_ub_n, r_lb_n} : '0;

  assign l_sem_go = ~l_sem_n & (l_cen_n | (l_ub_n & l_lb_n));
  assign r_sem_go = ~r_sem_n & (r_cen_n | (r_ub_n & r_lb_n));

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (r_we[k]) mem[r_addr][k*LW +: LW] <= r_wdata[k*LW +: LW];
      if (l_we[k]) mem[l_addr][k*LW +: LW] <= l_wdata[k*LW +: LW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata  <= '0;
      r_rdata  <= '0;
      l_rvalid <= '0;
      r_rvalid <= '0;
      collide  <= 1'b0;
    end else begin
      l_rvalid <= l_re;
      r_rvalid <= r_re;
      for (int k = 0; k < LANES; k++) begin
        l_rdata[k*LW +: LW] <= l_re[k] ? mem[l_addr][k*LW +: LW] : '0;
        r_rdata[k*LW +: LW] <= r_re[k] ? mem[r_addr][k*LW +: LW] : '0;
      end
      collide <= (|l_we) & (|r_we) & (l_addr == r_addr);
    end
  end

  assert_oe_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_oe_n && r_oe_n) |=> (l_rvalid == 2'b00 && r_rvalid == 2'b00));

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cen_n && l_sem_n) |=> (l_rvalid == 2'b00));

  assert_illegal_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sem_n && !l_cen_n && !(l_ub_n && l_lb_n)) |=> (l_rvalid == 2'b00 && !$past(l_sem_go)));

  assert_collide_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> $past(!l_rw_n && !r_rw_n && !l_cen_n && !r_cen_n && l_addr == r_addr));

  assert_idle_lane_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_rvalid[1] |-> l_rdata[DATA_W-1:LW] == '0) and (!l_rvalid[0] |-> l_rdata[LW-1:0] == '0)
    and (!r_rvalid[1] |-> r_rdata[DATA_W-1:LW] == '0) and (!r_rvalid[0] |-> r_rdata[LW-1:0] == '0));

  assert_write_no_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_rw_n) |=> (r_rvalid == 2'b00));
endmodule

// File: tb/dpram_lanes_tb.sv
module dpram_lanes_tb_top;
  typedef struct packed {
    logic [11:0] addr;
    logic cen_n, rw_n, oe_n, ub_n, lb_n, sem_n;
    logic [15:0] wdata;
  } port_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] l_addr, r_addr;
  logic l_cen_n, l_rw_n, l_oe_n, l_ub_n, l_lb_n, l_sem_n;
  logic r_cen_n, r_rw_n, r_oe_n, r_ub_n, r_lb_n, r_sem_n;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic [1:0] l_rvalid, r_rvalid;
  logic l_sem_go, r_sem_go, collide;
  int checks = 0, fails = 0;
  logic [15:0] model [4096];

  always #5 clk = ~clk;

  dpram_lanes dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_cen_n(l_cen_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n),
    .l_ub_n(l_ub_n), .l_lb_n(l_lb_n), .l_sem_n(l_sem_n), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_sem_go(l_sem_go),
    .r_addr(r_addr), .r_cen_n(r_cen_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n),
    .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_sem_n(r_sem_n), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_sem_go(r_sem_go),
    .collide(collide)
  );

  function automatic port_t mk(input logic [11:0] a, input logic ce, rw, oe, ub, lb, sm,
                               input logic [15:0] d);
    port_t p;
    p.addr = a; p.cen_n = ce; p.rw_n = rw; p.oe_n = oe;
    p.ub_n = ub; p.lb_n = lb; p.sem_n = sm; p.wdata = d;
    return p;
  endfunction

  function automatic logic [1:0] exp_valid(input port_t p);
    return (p.sem_n && !p.cen_n && p.rw_n && !p.oe_n) ? ~{p.ub_n, p.lb_n} : 2'b00;
  endfunction

  function automatic logic [1:0] wmask(input port_t p);
    return (p.sem_n && !p.cen_n && !p.rw_n) ? ~{p.ub_n, p.lb_n} : 2'b00;
  endfunction

  function automatic logic semgo(input port_t p);
    return !p.sem_n && (p.cen_n || (p.ub_n && p.lb_n));
  endfunction

  function automatic logic [15:0] lanes(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  function automatic string mode_tag(input port_t p);
    if (!p.sem_n) return semgo(p) ? "R8" : "R9";
    if (p.cen_n) return "R2";
    if (p.ub_n && p.lb_n) return "R3";
    if (!p.rw_n) return "R4";
    if (p.oe_n) return "R6";
    return "R5";
  endfunction

  function automatic string dtag(input port_t a, input port_t b);
    if (exp_valid(a) != 0 && wmask(b) != 0 && a.addr == b.addr) return "R11";
    if (exp_valid(a) != 0 && exp_valid(b) != 0 && a.addr == b.addr) return "R7";
    return mode_tag(a);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_cycle(input port_t L, input port_t R);
    logic [1:0] evl, evr;
    logic [15:0] edl, edr;
    logic ec;
    l_addr = L.addr; l_cen_n = L.cen_n; l_rw_n = L.rw_n; l_oe_n = L.oe_n;
    l_ub_n = L.ub_n; l_lb_n = L.lb_n; l_sem_n = L.sem_n; l_wdata = L.wdata;
    r_addr = R.addr; r_cen_n = R.cen_n; r_rw_n = R.rw_n; r_oe_n = R.oe_n;
    r_ub_n = R.ub_n; r_lb_n = R.lb_n; r_sem_n = R.sem_n; r_wdata = R.wdata;
    #1;
    chk(mode_tag(L), "left sem_go", {31'd0, l_sem_go}, {31'd0, semgo(L)});
    chk(mode_tag(R), "right sem_go", {31'd0, r_sem_go}, {31'd0, semgo(R)});
    evl = exp_valid(L); evr = exp_valid(R);
    edl = lanes(model[L.addr], evl); edr = lanes(model[R.addr], evr);
    ec = (wmask(L) != 0) && (wmask(R) != 0) && (L.addr == R.addr);
    for (int k = 0; k < 2; k++) begin
      if (wmask(R)[k]) model[R.addr][k*8 +: 8] = R.wdata[k*8 +: 8];
      if (wmask(L)[k]) model[L.addr][k*8 +: 8] = L.wdata[k*8 +: 8];
    end
    @(posedge clk); @(negedge clk);
    chk(mode_tag(L), "left rvalid", {30'd0, l_rvalid}, {30'd0, evl});
    chk(dtag(L, R), "left rdata", {16'd0, l_rdata}, {16'd0, edl});
    chk(mode_tag(R), "right rvalid", {30'd0, r_rvalid}, {30'd0, evr});
    chk(dtag(R, L), "right rdata", {16'd0, r_rdata}, {16'd0, edr});
    chk("R10", "collide", {31'd0, collide}, {31'd0, ec});
  endtask

  function automatic logic [11:0] pool_addr(input int i);
    return (i < 16) ? 12'(i) : 12'(4080 + i - 16);
  endfunction

  port_t idle;

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle = mk(12'd0, 1, 1, 1, 1, 1, 1, 16'h0);
    l_addr = 0; l_cen_n = 1; l_rw_n = 1; l_oe_n = 1; l_ub_n = 1; l_lb_n = 1; l_sem_n = 1; l_wdata = 0;
    r_addr = 0; r_cen_n = 1; r_rw_n = 1; r_oe_n = 1; r_ub_n = 1; r_lb_n = 1; r_sem_n = 1; r_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "reset l_rvalid", {30'd0, l_rvalid}, 32'd0);
    chk("R12", "reset r_rvalid", {30'd0, r_rvalid}, 32'd0);
    chk("R12", "reset rdata", {l_rdata, r_rdata}, 32'd0);
    chk("R12", "reset collide", {31'd0, collide}, 32'd0);

    for (int i = 0; i < 16; i++)
      do_cycle(mk(pool_addr(i), 0, 0, 1, 0, 0, 1, 16'($urandom)),
               mk(pool_addr(i + 16), 0, 0, 0, 0, 0, 1, 16'($urandom)));

    // R1 boundary word written right, read left
    do_cycle(idle, mk(12'd4095, 0, 0, 1, 0, 0, 1, 16'hBEEF));
    do_cycle(mk(12'd4095, 0, 1, 0, 0, 0, 1, 16'h0), idle);
    chk("R1", "word 4095 readback", {16'd0, l_rdata}, 32'h0000BEEF);
    // R4 upper-only write with output gate low
    do_cycle(mk(12'd3, 0, 0, 0, 0, 1, 1, 16'hA55A), idle);
    do_cycle(idle, mk(12'd3, 0, 1, 0, 0, 0, 1, 16'h0));
    // R10 partial-lane collision
    do_cycle(mk(12'd5, 0, 0, 1, 0, 1, 1, 16'h1122), mk(12'd5, 0, 0, 1, 0, 0, 1, 16'h3344));
    do_cycle(mk(12'd5, 0, 1, 0, 0, 0, 1, 16'h0), idle);
    chk("R10", "merged word", {16'd0, l_rdata}, 32'h00001144);
    // R11 read beside write
    do_cycle(mk(12'd7, 0, 1, 0, 0, 0, 1, 16'h0), mk(12'd7, 0, 0, 1, 0, 0, 1, 16'h7777));
    // R7 dual read
    do_cycle(mk(12'd7, 0, 1, 0, 0, 0, 1, 16'h0), mk(12'd7, 0, 1, 0, 0, 0, 1, 16'h0));
    chk("R7", "both see new word", {l_rdata, r_rdata}, 32'h77777777);
    // R8 hand-off, R9 illegal write, R3 lane-less write, R6 gate high
    do_cycle(mk(12'd8, 1, 0, 1, 0, 0, 0, 16'hDEAD), mk(12'd8, 0, 0, 1, 1, 1, 0, 16'hDEAD));
    do_cycle(mk(12'd8, 0, 0, 1, 0, 0, 0, 16'hDEAD), mk(12'd9, 0, 0, 1, 1, 1, 1, 16'hDEAD));
    do_cycle(mk(12'd8, 0, 1, 1, 0, 0, 1, 16'h0), idle);
    do_cycle(mk(12'd8, 0, 1, 0, 0, 0, 1, 16'h0), mk(12'd9, 0, 1, 0, 0, 0, 1, 16'h0));

    for (int n = 0; n < 3000; n++) begin
      port_t p [2];
      for (int s = 0; s < 2; s++) begin
        p[s] = mk(pool_addr(int'($urandom % 32)),
                  ($urandom % 5) == 0, $urandom % 2, ($urandom % 5) == 0,
                  ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 10) != 0,
                  16'($urandom));
      end
      do_cycle(p[0], p[1]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule